// File: doc/BRIEF.md
# UART Baud Source Select and Framing-Flag Alias

This block is the rate and control helper for a classic 8-bit microcontroller UART. It produces the bit-rate enable pulse that the shift and sampling logic consume. Three control bits come from the power/serial control register: a rate-double bit (bit 7), a framing-check enable (bit 6) and a tick-source select (bit 5). That register resets to 00h and is written through the block's write strobe. In the variable-rate modes (1 and 3), the tick is built from overflow pulses of one of two timers. In the fixed-rate modes (0 and 2), it comes from a system-clock divider.

The block also owns the top two bits of the serial control register: the two mode bits. Bit 7 of that register is shared. When the framing-check enable is 0, reads and writes of bit 7 reach the high mode bit. When it is 1, they reach a framing-error flag. The receiver sets that flag with a one-cycle pulse. Both stored values are always kept, whichever one is currently visible.

All pins are plain control and status signals. There are no data streams, so no valid/ready handshake is used. A write strobe is acted on in the cycle it is high, and there is no back-pressure.

Top module: `uart_baud_alias`

## Requirements
- R1: After reset, the control bits, both mode bits and the framing-error flag are all 0, the bit-7 read value is 0 and no tick is produced.
- R2: A control write stores wr_data bit 7 as rate-double, bit 6 as framing-check enable and bit 5 as source select. The new values take effect from the next cycle.
- R3: In modes 1 and 3, source select 0 counts Timer0 overflow pulses and 1 counts Timer1 overflow pulses. Pulses from the unselected timer have no effect.
- R4: In modes 1 and 3, rate-double 0 gives one tick per 32 selected overflows (a divide-by-2 prescaler ahead of a divide-by-16). Rate-double 1 gives one tick per 16 overflows.
- R5: In mode 2, a tick occurs every 64 clock cycles, or every 32 when rate-double is 1. Timer overflows and source select have no effect.
- R6: In mode 0, a tick occurs every 12 clock cycles, whatever the rate-double, source select and overflow inputs.
- R7: baud_tick is a registered one-cycle pulse. It is high in the cycle after the clock edge that completes the count.
- R8: Any write to either register clears the prescaler and the divider, with no tick in the cycle that follows.
- R9: With framing-check enable 1, bit 7 reads the framing-error flag. A register write with bit 7 at 0 clears the flag, a write with bit 7 at 1 leaves it unchanged, and the stored high mode bit is not altered.
- R10: With framing-check enable 0, bit 7 reads and writes the high mode bit, and the framing-error flag keeps its value.
- R11: fe_event sets the framing-error flag whatever the framing-check enable. When a clearing write and fe_event fall in the same cycle, the flag ends up set.
- R12: The mode is {high mode bit, low mode bit}. The low mode bit is taken from wr_data bit 6 on every register write: 00 is mode 0, 01 mode 1, 10 mode 2, 11 mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t0_ovf | input | 1 | Timer0 overflow pulse |
| t1_ovf | input | 1 | Timer1 overflow pulse |
| scon_wr | input | 1 | Write strobe for the serial control register |
| pcon_wr | input | 1 | Write strobe for the power/serial control register |
| wr_data | input | 8 | Write data shared by both strobes |
| fe_event | input | 1 | Receiver reports a low stop bit |
| baud_tick | output | 1 | Bit-rate enable pulse |
| scon_b7_rd | output | 1 | Read value of serial control bit 7 |

## Verification
The in-line assertions check several rules on every cycle. A register write always leaves the divider empty and the tick low. A tick never lasts two cycles. With rate-double 0, an accepted overflow never follows another one directly. The framing flag and the high mode bit change only through the paths that are allowed to move them. The exact tick ratio for each combination of double and source bits can only be shown by the bench's counted scenarios, and so can the fixed divides of modes 0 and 2, the restart of an interrupted count after a write, and the read value of the shared bit across toggles of the enable. The bench covers these with a per-cycle reference model and tick tallies.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic [1:0] {
    SER_M0 = 2'b00,
    SER_M1 = 2'b01,
    SER_M2 = 2'b10,
    SER_M3 = 2'b11
  } ser_mode_e;

  typedef struct packed {
    logic dbl;
    logic fee;
    logic src;
  } ctl_bits_t;
endpackage

// File: rtl/bsa_b7_alias.sv
module bsa_b7_alias
  import bsa_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scon_wr,
  input  logic      wr_b7,
  input  logic      wr_b6,
  input  logic      fee,
  input  logic      fe_event,
  output ser_mode_e mode,
  output logic      rd_b7
);
  logic sm0_q, sm1_q, fe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sm0_q <= 1'b0;
      sm1_q <= 1'b0;
      fe_q  <= 1'b0;
    end else begin
      if (scon_wr) begin
        sm1_q <= wr_b6;
        if (!fee) sm0_q <= wr_b7;
        else if (!wr_b7) fe_q <= 1'b0;
      end
      if (fe_event) fe_q <= 1'b1;
    end
  end

  assign mode  = ser_mode_e'({sm0_q, sm1_q});
  assign rd_b7 = fee ? fe_q : sm0_q;

  p_fe_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fe_event |=> fe_q);
  p_fe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_event && !(scon_wr && fee && !wr_b7)) |=> $stable(fe_q));
  p_sm0_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(scon_wr && !fee) |=> $stable(sm0_q));
endmodule

// File: rtl/bsa_prescale.sv
module bsa_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic t0_ovf,
  input  logic t1_ovf,
  input  logic src_sel,
  input  logic dbl,
  input  logic var_mode,
  input  logic clr,
  output logic adv
);
  logic pick, ph_q;

  assign pick = src_sel ? t1_ovf : t0_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ph_q <= 1'b0;
    else if (clr)                       ph_q <= 1'b0;
    else if (var_mode && pick && !dbl)  ph_q <= ~ph_q;
  end

  assign adv = var_mode && !clr && pick && (dbl || ph_q);

  p_half_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !dbl) |=> !adv);
endmodule

// File: rtl/bsa_bitdiv.sv
module bsa_bitdiv
  import bsa_pkg::*;
#(
  parameter int OVF_DIV = 16,
  parameter int M2_DIV  = 64,
  parameter int M0_DIV  = 12
) (
  input  logic      clk,
  input  logic      rst_n,
  input  ser_mode_e mode,
  input  logic      dbl,
  input  logic      adv,
  input  logic      clr,
  output logic      tick
);
  localparam int MAX_A = (OVF_DIV > M0_DIV) ? OVF_DIV : M0_DIV;
  localparam int MAXD  = (M2_DIV > MAX_A) ? M2_DIV : MAX_A;
  localparam int CW    = $clog2(MAXD);

  logic [CW-1:0] cnt_q, last;
  logic          var_m, en, tick_q;

  assign var_m = (mode == SER_M1) || (mode == SER_M3);
  assign en    = var_m ? adv : 1'b1;

  always_comb begin
    case (mode)
      SER_M0:  last = CW'(M0_DIV - 1);
      SER_M2:  last = dbl ? CW'(M2_DIV / 2 - 1) : CW'(M2_DIV - 1);
      default: last = CW'(OVF_DIV - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (en) begin
      if (cnt_q == last) begin
        cnt_q  <= '0;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !tick_q));
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
  p_var_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (var_m && !adv) |=> !tick_q);
endmodule

// File: rtl/uart_baud_alias.sv
module uart_baud_alias
  import bsa_pkg::*;
#(
  parameter int OVF_DIV = 16,
  parameter int M2_DIV  = 64,
  parameter int M0_DIV  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       t0_ovf,
  input  logic       t1_ovf,
  input  logic       scon_wr,
  input  logic       pcon_wr,
  input  logic [7:0] wr_data,
  input  logic       fe_event,
  output logic       baud_tick,
  output logic       scon_b7_rd
);
  ctl_bits_t ctl_q;
  ser_mode_e mode;
  logic      clr, adv, var_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= '0;
    else if (pcon_wr) ctl_q <= '{dbl: wr_data[7], fee: wr_data[6], src: wr_data[5]};
  end

  assign clr      = scon_wr | pcon_wr;
  assign var_mode = (mode == SER_M1) || (mode == SER_M3);

  bsa_b7_alias u_alias (
    .clk(clk), .rst_n(rst_n), .scon_wr(scon_wr), .wr_b7(wr_data[7]),
    .wr_b6(wr_data[6]), .fee(ctl_q.fee), .fe_event(fe_event),
    .mode(mode), .rd_b7(scon_b7_rd)
  );

  bsa_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .t0_ovf(t0_ovf), .t1_ovf(t1_ovf),
    .src_sel(ctl_q.src), .dbl(ctl_q.dbl), .var_mode(var_mode),
    .clr(clr), .adv(adv)
  );

  bsa_bitdiv #(.OVF_DIV(OVF_DIV), .M2_DIV(M2_DIV), .M0_DIV(M0_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dbl(ctl_q.dbl),
    .adv(adv), .clr(clr), .tick(baud_tick)
  );

  p_ctl_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pcon_wr |=> (ctl_q.dbl == $past(wr_data[7]) && ctl_q.src == $past(wr_data[5])));
endmodule

// File: tb/uart_baud_alias_tb_top.sv
module uart_baud_alias_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic t0_ovf = 0, t1_ovf = 0, scon_wr = 0, pcon_wr = 0, fe_event = 0;
  logic [7:0] wr_data = 8'h00;
  logic baud_tick, scon_b7_rd;
  int total = 0, bad = 0, ticks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_baud_alias dut_i (.*);

  // behavioural reference state
  int m_dbl, m_fee, m_src, m_sm0, m_sm1, m_fe, m_ph, m_cnt, m_tick;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dbl = 0; m_fee = 0; m_src = 0; m_sm0 = 0; m_sm1 = 0;
      m_fe = 0; m_ph = 0; m_cnt = 0; m_tick = 0;
    end else begin
      int md, lim, s, a;
      md = m_sm0 * 2 + m_sm1;
      m_tick = 0;
      if (scon_wr || pcon_wr) begin
        m_cnt = 0; m_ph = 0;
      end else if (md == 1 || md == 3) begin
        s = m_src ? int'(t1_ovf) : int'(t0_ovf);
        a = 0;
        if (s == 1) begin
          if (m_dbl == 1) a = 1;
          else begin a = m_ph; m_ph = 1 - m_ph; end
        end
        if (a == 1) begin
          m_cnt++;
          if (m_cnt == 16) begin m_cnt = 0; m_tick = 1; end
        end
      end else begin
        lim = (md == 0) ? 12 : (m_dbl == 1 ? 32 : 64);
        m_cnt++;
        if (m_cnt == lim) begin m_cnt = 0; m_tick = 1; end
      end
      if (pcon_wr) begin
        m_dbl = wr_data[7]; m_fee = wr_data[6]; m_src = wr_data[5];
      end
      if (scon_wr) begin
        m_sm1 = wr_data[6];
        if (m_fee == 0) m_sm0 = wr_data[7];
        else if (wr_data[7] == 1'b0) m_fe = 0;
      end
      if (fe_event) m_fe = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, plus tick tally (R7)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 tick vs model", int'(baud_tick), m_tick);
      chk("R9/R10 bit7 vs model", int'(scon_b7_rd), (m_fee == 1) ? m_fe : m_sm0);
      if (baud_tick) ticks++;
    end
  end

  task automatic settle(); @(negedge clk); #1; endtask

  task automatic wr(bit is_pcon, logic [7:0] d);
    @(posedge clk); #1;
    wr_data = d;
    if (is_pcon) pcon_wr = 1; else scon_wr = 1;
    @(posedge clk); #1;
    pcon_wr = 0; scon_wr = 0;
  endtask

  // pulse the chosen timer n times; the other timer pulses in between
  task automatic pulses(int n, bit use_t1);
    for (int i = 0; i < n; i++) begin
      if (use_t1) t1_ovf = 1; else t0_ovf = 1;
      @(posedge clk); #1;
      t0_ovf = 0; t1_ovf = 0;
      if (use_t1) t0_ovf = 1; else t1_ovf = 1;
      @(posedge clk); #1;
      t0_ovf = 0; t1_ovf = 0;
    end
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    settle();
    chk("R1 reset bit7", int'(scon_b7_rd), 0);
    chk("R1 reset tick", int'(baud_tick), 0);

    // R3 R4 R12: variable modes, every double/source combination
    for (int md = 1; md <= 3; md += 2) begin
      for (int dbl = 0; dbl < 2; dbl++) begin
        for (int src = 0; src < 2; src++) begin
          wr(1'b0, (md == 3) ? 8'hC0 : 8'h40);
          wr(1'b1, {dbl[0], 1'b0, src[0], 5'b0});  // R2 field positions
          base = ticks;
          pulses(64, src[0]);
          repeat (3) settle();
          chk($sformatf("R4 m%0d dbl=%0d src=%0d ticks", md, dbl, src),
              ticks - base, dbl ? 4 : 2);
          wr(1'b1, {dbl[0], 1'b0, src[0], 5'b0});
          base = ticks;
          for (int i = 0; i < 64; i++) begin
            if (src) t0_ovf = 1; else t1_ovf = 1;
            @(posedge clk); #1; t0_ovf = 0; t1_ovf = 0;
          end
          repeat (2) settle();
          chk($sformatf("R3 unselected m%0d src=%0d", md, src), ticks - base, 0);
        end
      end
    end

    // R5 mode 2 fixed divide, overflows ignored
    for (int dbl = 0; dbl < 2; dbl++) begin
      wr(1'b0, 8'h80);
      wr(1'b1, {dbl[0], 2'b01, 5'b0});
      base = ticks;
      pulses(64, 1'b0);
      repeat (3) settle();
      chk($sformatf("R5 mode2 dbl=%0d", dbl), ticks - base, dbl ? 4 : 2);
    end

    // R6 mode 0 every 12 cycles regardless of control bits
    wr(1'b1, 8'hA0);
    wr(1'b0, 8'h00);
    base = ticks;
    pulses(60, 1'b1);
    repeat (3) settle();
    chk("R6 mode0 ticks", ticks - base, 10);

    // R8 write restarts the divider (mode 2, /64)
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h80);
    repeat (40) @(posedge clk);
    wr(1'b1, 8'h00);
    base = ticks;
    repeat (63) @(posedge clk);
    settle();
    chk("R8 no tick before restart count", ticks - base, 0);
    @(posedge clk);
    settle();
    chk("R8 tick after full count", ticks - base, 1);

    // R10 R11 R9 shared bit 7
    wr(1'b0, 8'hC0);
    settle();
    chk("R10 bit7 shows SM0", int'(scon_b7_rd), 1);
    @(posedge clk); #1 fe_event = 1; @(posedge clk); #1 fe_event = 0;
    settle();
    chk("R10 FE set hidden, SM0 shown", int'(scon_b7_rd), 1);
    wr(1'b1, 8'h40);
    settle();
    chk("R11 FE set while disabled", int'(scon_b7_rd), 1);
    wr(1'b0, 8'h80);
    settle();
    chk("R9 write 1 keeps FE", int'(scon_b7_rd), 1);
    wr(1'b0, 8'h00);
    settle();
    chk("R9 write 0 clears FE", int'(scon_b7_rd), 0);
    wr(1'b1, 8'h00);
    settle();
    chk("R9 SM0 untouched by FE writes", int'(scon_b7_rd), 1);
    wr(1'b1, 8'h40);
    @(posedge clk); #1;
    wr_data = 8'h00; scon_wr = 1; fe_event = 1;
    @(posedge clk); #1;
    scon_wr = 0; fe_event = 0;
    settle();
    chk("R11 set beats clear", int'(scon_b7_rd), 1);
    wr(1'b0, 8'h00);
    settle();
    chk("R9 clear then 0", int'(scon_b7_rd), 0);
    wr(1'b1, 8'h00);
    settle();
    chk("R12 SM0 kept from mode 3 write", int'(scon_b7_rd), 1);

    repeat (5) settle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule